// File: doc/BRIEF.md
# Miss Buffer Blocking Controller

This block keeps the request bookkeeping of a non-blocking cache: how full the miss-register pool is, and how full the write/writeback buffer is. An allocation request comes with a kind (cacheable miss, write, or uncached read), an address and a size. The block steers the request to the matching buffer, shapes its address and size, and stamps it with a tag from one order counter that both buffers share. The shaped result appears one cycle later. When an accepted allocation asks for it, the block also raises a memory-side bus request that carries a cause code.

Three causes can stall the CPU-side request port: a full miss pool, a full write buffer, and no free targets. Each cause has its own bit in a blocked mask, and the port stays stalled while any bit is set. A bit is raised when its buffer fills and dropped when an in-service event frees space in it. The per-cause statistics are edge-sensitive. A blocking-event count moves only when the mask leaves zero. A blocked-cycle total moves only when the mask returns to zero, and it is charged to the cause whose clearing released the port. A loadable miss limit counts cacheable misses down and emits a single-cycle halt pulse when it runs out.

Top module: `mbc_ctrl`

## Requirements
- R1: `cpu_blocked` is 1 exactly in the cycles when `block_mask` is nonzero. Mask bit 0 stands for a full miss pool, bit 1 for a full write buffer, and bit 2 for no free targets. After reset the mask is 0.
- R2: An allocation that makes its buffer full sets that buffer's mask bit. An in-service pulse (`svc_miss`, `svc_wbuf`) that takes a full buffer to not full clears the bit. Bit 2 follows `tgt_set`/`tgt_clr`, and set wins when both are high in the same cycle.
- R3: An allocation and an in-service pulse on the same buffer in the same cycle are netted first. The allocation is accepted even when the buffer is full, and the mask bit follows the resulting full state. An allocation to a full buffer with no in-service pulse is dropped, and so is an allocation of kind 3. A dropped allocation produces no output and consumes no tag.
- R4: The event counter of a cause (`blk_events`, field c at bits c*STAT_W) is incremented only in a cycle when the mask goes from zero to nonzero and that cause is being set. Setting a cause while the mask is already nonzero changes no counter.
- R5: When the mask returns to zero, the number of cycles it was nonzero is added to the `blk_cycles` field of the cause cleared in that cycle (the highest cleared index if several). The other causes' fields are unchanged.
- R6: A cacheable miss (kind 0) is reported on buffer 0 with its address rounded down to a multiple of BLK_BYTES and size equal to BLK_BYTES.
- R7: A write (kind 1) is reported on buffer 1 and an uncached read (kind 2) on buffer 0, both with the exact address and size. The result (`out_valid` and the fields) appears one cycle after the allocation.
- R8: Accepted allocations carry tags 0, 1, 2, … from one counter shared by both buffers.
- R9: An accepted allocation with `alloc_bus_req` raises `bus_req` one cycle later, with `bus_cause` equal to its buffer (0 miss, 1 write). `pf_req` raises cause 2, and an allocation request wins over it. No request is raised in a cycle when `retry_wait` is high.
- R10: Loading the miss limit with N>0 makes `halt_pulse` high for exactly one cycle, following the N-th accepted cacheable miss. While the count is zero, misses do not pulse.
- R11: Reset clears the occupancies, the mask, the order counter, the outputs and all statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_kind | input | 2 | 0 miss, 1 write, 2 uncached read, 3 ignored |
| alloc_addr | input | ADDR_W | Request address |
| alloc_size | input | SIZE_W | Request size in bytes |
| alloc_bus_req | input | 1 | Allocation asks for the memory-side bus |
| svc_miss | input | 1 | An entry of the miss pool goes into service |
| svc_wbuf | input | 1 | An entry of the write buffer goes into service |
| tgt_set | input | 1 | Raise the no-targets cause |
| tgt_clr | input | 1 | Drop the no-targets cause |
| pf_req | input | 1 | Prefetch bus request |
| retry_wait | input | 1 | Memory-side port is waiting on a retry |
| limit_load | input | 1 | Load the miss limit |
| limit_value | input | LIMIT_W | Value for the miss limit |
| out_valid | output | 1 | Shaped allocation valid |
| out_buf | output | 1 | Target buffer (0 miss pool, 1 write buffer) |
| out_addr | output | ADDR_W | Shaped address |
| out_size | output | SIZE_W | Shaped size |
| out_tag | output | ORDER_W | Order tag |
| out_kind | output | 2 | Kind of the reported allocation |
| bus_req | output | 1 | Memory-side bus request pulse |
| bus_cause | output | 2 | Cause code of the bus request |
| cpu_blocked | output | 1 | CPU-side port stall |
| block_mask | output | 3 | Per-cause blocked mask |
| miss_occ | output | OCC_W | Miss pool occupancy |
| wbuf_occ | output | OCC_W | Write buffer occupancy |
| blk_events | output | 3*STAT_W | Per-cause blocking-event counters |
| blk_cycles | output | 3*STAT_W | Per-cause blocked-cycle totals |
| halt_pulse | output | 1 | One-cycle halt when the miss limit runs out |

## Verification
Some properties are checked by assertions on every cycle. The stall output must agree with the mask, and each buffer bit must match its buffer's full state. Consecutive tags must step by one, and miss results must be block-shaped. The halt pulse must last one cycle, no bus request may follow a retry-wait cycle, and the statistics may move only on mask edges. Other behaviour shows up only in the bench's scenarios. These cover the exact blocked-cycle totals charged to the cause that released the port, the choice of counter when several causes are set together, and netting a same-cycle allocation and in-service pulse on a full buffer. They also cover dropped requests consuming no tag, the priority of allocation over prefetch, and the countdown to the halt.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [1:0] {
    KIND_MISS   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_UNC_RD = 2'd2,
    KIND_NONE   = 2'd3
  } alloc_kind_e;

  localparam int NUM_BUFS   = 2;
  localparam int BUF_MISS   = 0;
  localparam int BUF_WBUF   = 1;
  localparam int NUM_CAUSES = 3;
  localparam int CAUSE_TGT  = 2;

  localparam logic [1:0] REQ_PREFETCH = 2'd2;

endpackage

// File: rtl/mbc_occ_tracker.sv
module mbc_occ_tracker #(
  parameter int DEPTH = 4,
  parameter int OW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          svc_req,
  output logic          accept,
  output logic          full_set,
  output logic          full_clr,
  output logic [OW-1:0] occ
);

  localparam logic [OW-1:0] DEPTH_V = OW'(DEPTH);

  logic [OW-1:0] occ_q;
  logic [OW-1:0] occ_d;
  logic          svc_eff;
  logic          full_now;
  logic          full_next;

  function automatic logic [OW-1:0] net_occ(logic [OW-1:0] cur, logic inc, logic dec);
    return cur + OW'(inc) - OW'(dec);
  endfunction

  assign svc_eff   = svc_req && (occ_q != '0);
  assign accept    = alloc_req && ((occ_q < DEPTH_V) || svc_eff);
  assign occ_d     = net_occ(occ_q, accept, svc_eff);
  assign full_now  = (occ_q == DEPTH_V);
  assign full_next = (occ_d == DEPTH_V);
  assign full_set  = !full_now && full_next;
  assign full_clr  = full_now && !full_next;
  assign occ       = occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

endmodule

// File: rtl/mbc_block_stats.sv
module mbc_block_stats #(
  parameter int NC     = 3,
  parameter int STAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NC-1:0]        set_vec,
  input  logic [NC-1:0]        clr_vec,
  output logic [NC-1:0]        mask,
  output logic                 blocked,
  output logic                 start_ev,
  output logic                 end_ev,
  output logic [NC*STAT_W-1:0] events_flat,
  output logic [NC*STAT_W-1:0] cycles_flat
);

  logic [NC-1:0]     mask_q;
  logic [NC-1:0]     mask_d;
  logic              blocked_q;
  logic [STAT_W-1:0] now_q;
  logic [STAT_W-1:0] start_q;
  logic [STAT_W-1:0] evt_q [NC];
  logic [STAT_W-1:0] cyc_q [NC];
  int unsigned       last_idx;

  function automatic int unsigned top_cause(logic [NC-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < NC; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [STAT_W-1:0] elapsed(logic [STAT_W-1:0] now, logic [STAT_W-1:0] from);
    return now - from;
  endfunction

  assign mask_d   = (mask_q & ~clr_vec) | set_vec;
  assign start_ev = (mask_q == '0) && (mask_d != '0);
  assign end_ev   = (mask_q != '0) && (mask_d == '0);
  assign last_idx = top_cause(clr_vec & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      blocked_q <= 1'b0;
      now_q     <= '0;
      start_q   <= '0;
      for (int c = 0; c < NC; c++) begin
        evt_q[c] <= '0;
        cyc_q[c] <= '0;
      end
    end else begin
      now_q     <= now_q + 1'b1;
      mask_q    <= mask_d;
      blocked_q <= (mask_d != '0);
      if (start_ev) start_q <= now_q;
      for (int c = 0; c < NC; c++) begin
        if (start_ev && set_vec[c]) evt_q[c] <= evt_q[c] + 1'b1;
        if (end_ev && (last_idx == c)) cyc_q[c] <= cyc_q[c] + elapsed(now_q, start_q);
      end
    end
  end

  assign mask    = mask_q;
  assign blocked = blocked_q;

  for (genvar g = 0; g < NC; g++) begin : g_flat
    assign events_flat[g*STAT_W +: STAT_W] = evt_q[g];
    assign cycles_flat[g*STAT_W +: STAT_W] = cyc_q[g];
  end

endmodule

// File: rtl/mbc_miss_limit.sv
module mbc_miss_limit #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LIMIT_W-1:0] load_val,
  input  logic               miss_ev,
  output logic               halt
);

  logic [LIMIT_W-1:0] cnt_q;
  logic               halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      halt_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (miss_ev && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == LIMIT_W'(1)) halt_q <= 1'b1;
      end
    end
  end

  assign halt = halt_q;

endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
#(
  parameter int MISS_DEPTH = 4,
  parameter int WBUF_DEPTH = 2,
  parameter int BLK_BYTES  = 64,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 8,
  parameter int ORDER_W    = 16,
  parameter int STAT_W     = 32,
  parameter int LIMIT_W    = 16,
  localparam int MAX_DEPTH = (MISS_DEPTH > WBUF_DEPTH) ? MISS_DEPTH : WBUF_DEPTH,
  localparam int OCC_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  input  logic [1:0]                   alloc_kind,
  input  logic [ADDR_W-1:0]            alloc_addr,
  input  logic [SIZE_W-1:0]            alloc_size,
  input  logic                         alloc_bus_req,
  input  logic                         svc_miss,
  input  logic                         svc_wbuf,
  input  logic                         tgt_set,
  input  logic                         tgt_clr,
  input  logic                         pf_req,
  input  logic                         retry_wait,
  input  logic                         limit_load,
  input  logic [LIMIT_W-1:0]           limit_value,
  output logic                         out_valid,
  output logic                         out_buf,
  output logic [ADDR_W-1:0]            out_addr,
  output logic [SIZE_W-1:0]            out_size,
  output logic [ORDER_W-1:0]           out_tag,
  output logic [1:0]                   out_kind,
  output logic                         bus_req,
  output logic [1:0]                   bus_cause,
  output logic                         cpu_blocked,
  output logic [NUM_CAUSES-1:0]        block_mask,
  output logic [OCC_W-1:0]             miss_occ,
  output logic [OCC_W-1:0]             wbuf_occ,
  output logic [NUM_CAUSES*STAT_W-1:0] blk_events,
  output logic [NUM_CAUSES*STAT_W-1:0] blk_cycles,
  output logic                         halt_pulse
);

  localparam logic [ADDR_W-1:0] BLK_LOW  = ADDR_W'(BLK_BYTES - 1);
  localparam logic [SIZE_W-1:0] BLK_SIZE = SIZE_W'(BLK_BYTES);

  alloc_kind_e         kind;
  logic                kind_ok;
  logic                alloc_buf;
  logic [NUM_BUFS-1:0] buf_alloc;
  logic [NUM_BUFS-1:0] buf_svc;
  logic [NUM_BUFS-1:0] buf_accept;
  logic [NUM_BUFS-1:0] buf_full_set;
  logic [NUM_BUFS-1:0] buf_full_clr;
  logic [OCC_W-1:0]    buf_occ [NUM_BUFS];
  logic                accepted;
  logic                miss_ev;
  logic                blk_start_ev;
  logic                blk_end_ev;
  logic [NUM_CAUSES-1:0] cause_set;
  logic [NUM_CAUSES-1:0] cause_clr;

  logic                out_valid_q;
  logic                out_buf_q;
  logic [ADDR_W-1:0]   out_addr_q;
  logic [SIZE_W-1:0]   out_size_q;
  logic [ORDER_W-1:0]  out_tag_q;
  logic [1:0]          out_kind_q;
  logic [ORDER_W-1:0]  order_q;
  logic                bus_req_q;
  logic [1:0]          bus_cause_q;

  function automatic logic [ADDR_W-1:0] shape_addr(alloc_kind_e k, logic [ADDR_W-1:0] a);
    return (k == KIND_MISS) ? (a & ~BLK_LOW) : a;
  endfunction

  function automatic logic [SIZE_W-1:0] shape_size(alloc_kind_e k, logic [SIZE_W-1:0] s);
    return (k == KIND_MISS) ? BLK_SIZE : s;
  endfunction

  function automatic logic buf_of(alloc_kind_e k);
    return (k == KIND_WRITE) ? 1'b1 : 1'b0;
  endfunction

  assign kind      = alloc_kind_e'(alloc_kind);
  assign kind_ok   = alloc_valid && (kind != KIND_NONE);
  assign alloc_buf = buf_of(kind);
  assign buf_svc   = {svc_wbuf, svc_miss};

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    localparam int DEPTH_B = (b == BUF_MISS) ? MISS_DEPTH : WBUF_DEPTH;
    assign buf_alloc[b] = kind_ok && (alloc_buf == b[0]);
    mbc_occ_tracker #(
      .DEPTH (DEPTH_B),
      .OW    (OCC_W)
    ) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_req (buf_alloc[b]),
      .svc_req   (buf_svc[b]),
      .accept    (buf_accept[b]),
      .full_set  (buf_full_set[b]),
      .full_clr  (buf_full_clr[b]),
      .occ       (buf_occ[b])
    );
  end

  assign accepted  = |buf_accept;
  assign miss_ev   = buf_accept[BUF_MISS] && (kind == KIND_MISS);
  assign cause_set = {tgt_set, buf_full_set};
  assign cause_clr = {tgt_clr, buf_full_clr};

  mbc_block_stats #(
    .NC     (NUM_CAUSES),
    .STAT_W (STAT_W)
  ) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (cause_set),
    .clr_vec     (cause_clr),
    .mask        (block_mask),
    .blocked     (cpu_blocked),
    .start_ev    (blk_start_ev),
    .end_ev      (blk_end_ev),
    .events_flat (blk_events),
    .cycles_flat (blk_cycles)
  );

  mbc_miss_limit #(
    .LIMIT_W (LIMIT_W)
  ) u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (limit_load),
    .load_val (limit_value),
    .miss_ev  (miss_ev),
    .halt     (halt_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_buf_q   <= 1'b0;
      out_addr_q  <= '0;
      out_size_q  <= '0;
      out_tag_q   <= '0;
      out_kind_q  <= KIND_MISS;
      order_q     <= '0;
    end else begin
      out_valid_q <= accepted;
      if (accepted) begin
        out_buf_q  <= alloc_buf;
        out_addr_q <= shape_addr(kind, alloc_addr);
        out_size_q <= shape_size(kind, alloc_size);
        out_tag_q  <= order_q;
        out_kind_q <= kind;
        order_q    <= order_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req_q   <= 1'b0;
      bus_cause_q <= '0;
    end else begin
      bus_req_q <= 1'b0;
      if (!retry_wait) begin
        if (accepted && alloc_bus_req) begin
          bus_req_q   <= 1'b1;
          bus_cause_q <= {1'b0, alloc_buf};
        end else if (pf_req) begin
          bus_req_q   <= 1'b1;
          bus_cause_q <= REQ_PREFETCH;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_buf   = out_buf_q;
  assign out_addr  = out_addr_q;
  assign out_size  = out_size_q;
  assign out_tag   = out_tag_q;
  assign out_kind  = out_kind_q;
  assign bus_req   = bus_req_q;
  assign bus_cause = bus_cause_q;
  assign miss_occ  = buf_occ[BUF_MISS];
  assign wbuf_occ  = buf_occ[BUF_WBUF];

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker
  import mbc_pkg::*;
#(
  parameter int MISS_DEPTH = 4,
  parameter int WBUF_DEPTH = 2,
  parameter int BLK_BYTES  = 64,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 8,
  parameter int ORDER_W    = 16,
  parameter int STAT_W     = 32,
  parameter int OCC_W      = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         retry_wait,
  input logic                         out_valid,
  input logic [1:0]                   out_kind,
  input logic [ADDR_W-1:0]            out_addr,
  input logic [SIZE_W-1:0]            out_size,
  input logic [ORDER_W-1:0]           out_tag,
  input logic                         bus_req,
  input logic                         cpu_blocked,
  input logic [NUM_CAUSES-1:0]        block_mask,
  input logic [OCC_W-1:0]             miss_occ,
  input logic [OCC_W-1:0]             wbuf_occ,
  input logic [NUM_CAUSES*STAT_W-1:0] blk_events,
  input logic [NUM_CAUSES*STAT_W-1:0] blk_cycles,
  input logic                         halt_pulse
);

  p_stall_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_blocked == (block_mask != '0));

  p_miss_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    block_mask[0] == (miss_occ == OCC_W'(MISS_DEPTH)));

  p_wbuf_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    block_mask[1] == (wbuf_occ == OCC_W'(WBUF_DEPTH)));

  p_events_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_events) |-> ($past(block_mask) == '0) && (block_mask != '0));

  p_cycles_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_cycles) |-> ($past(block_mask) != '0) && (block_mask == '0));

  p_miss_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0) |-> ((out_addr % BLK_BYTES) == 0) && (out_size == SIZE_W'(BLK_BYTES)));

  p_tag_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_tag == $past(out_tag) + 1'b1));

  p_no_req_on_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !$past(retry_wait));

  p_halt_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> !halt_pulse);

endmodule

bind mbc_ctrl mbc_checker #(
  .MISS_DEPTH (MISS_DEPTH),
  .WBUF_DEPTH (WBUF_DEPTH),
  .BLK_BYTES  (BLK_BYTES),
  .ADDR_W     (ADDR_W),
  .SIZE_W     (SIZE_W),
  .ORDER_W    (ORDER_W),
  .STAT_W     (STAT_W),
  .OCC_W      (OCC_W)
) u_mbc_checker (.*);

// File: tb/test_mbc_ctrl.sv
module test_mbc_ctrl;

  localparam int MD = 4;
  localparam int WD = 2;
  localparam int BLK = 64;
  localparam int SW = 32;

  typedef struct {
    logic        bsel;
    logic [31:0] addr;
    logic [7:0]  size;
    logic [15:0] tag;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_bus_req = 0, svc_miss = 0, svc_wbuf = 0;
  logic tgt_set = 0, tgt_clr = 0, pf_req = 0, retry_wait = 0, limit_load = 0;
  logic [1:0]  alloc_kind = 0;
  logic [31:0] alloc_addr = 0;
  logic [7:0]  alloc_size = 0;
  logic [15:0] limit_value = 0;

  logic        out_valid, out_buf, bus_req, cpu_blocked, halt_pulse;
  logic [31:0] out_addr;
  logic [7:0]  out_size;
  logic [15:0] out_tag;
  logic [1:0]  out_kind, bus_cause;
  logic [2:0]  block_mask, miss_occ, wbuf_occ;
  logic [3*SW-1:0] blk_events, blk_cycles;

  int total = 0;
  int bad = 0;
  int blk_seen = 0;
  int occ_m = 0;
  int occ_w = 0;
  logic [15:0] next_tag = 0;
  bit done = 0;
  exp_item_t sb[$];

  always #5 clk = ~clk;

  mbc_ctrl #(.MISS_DEPTH(MD), .WBUF_DEPTH(WD), .BLK_BYTES(BLK)) i_mbc_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_addr(alloc_addr), .alloc_size(alloc_size), .alloc_bus_req(alloc_bus_req),
    .svc_miss(svc_miss), .svc_wbuf(svc_wbuf), .tgt_set(tgt_set), .tgt_clr(tgt_clr),
    .pf_req(pf_req), .retry_wait(retry_wait), .limit_load(limit_load),
    .limit_value(limit_value), .out_valid(out_valid), .out_buf(out_buf),
    .out_addr(out_addr), .out_size(out_size), .out_tag(out_tag), .out_kind(out_kind),
    .bus_req(bus_req), .bus_cause(bus_cause), .cpu_blocked(cpu_blocked),
    .block_mask(block_mask), .miss_occ(miss_occ), .wbuf_occ(wbuf_occ),
    .blk_events(blk_events), .blk_cycles(blk_cycles), .halt_pulse(halt_pulse)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ev(input int c);
    return blk_events[c*SW +: SW];
  endfunction

  function automatic logic [31:0] cy(input int c);
    return blk_cycles[c*SW +: SW];
  endfunction

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic av, input logic [1:0] k, input logic [31:0] a, input logic [7:0] s,
                      input logic br, input logic sm, input logic sw,
                      input logic ts, input logic tc, input logic pf, input logic rw);
    int b;
    bit room;
    exp_item_t it;
    alloc_valid = av; alloc_kind = k; alloc_addr = a; alloc_size = s; alloc_bus_req = br;
    svc_miss = sm; svc_wbuf = sw; tgt_set = ts; tgt_clr = tc; pf_req = pf; retry_wait = rw;
    b = (k == 2'd1) ? 1 : 0;
    if (b == 0) room = (occ_m < MD) || (sm && occ_m > 0);
    else        room = (occ_w < WD) || (sw && occ_w > 0);
    if (sm && occ_m > 0) occ_m--;
    if (sw && occ_w > 0) occ_w--;
    if (av && k != 2'd3 && room) begin
      it.bsel = b[0];
      it.addr = (k == 2'd0) ? (a - (a % BLK)) : a;
      it.size = (k == 2'd0) ? 8'(BLK) : s;
      it.tag  = next_tag;
      next_tag++;
      sb.push_back(it);
      if (b == 0) occ_m++; else occ_w++;
    end
    @(negedge clk);
    alloc_valid = 0; alloc_bus_req = 0; svc_miss = 0; svc_wbuf = 0;
    tgt_set = 0; tgt_clr = 0; pf_req = 0; retry_wait = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: compares produced results with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_blocked) blk_seen++;
      if (out_valid) begin
        if (sb.size() == 0) begin
          check("R3", "unexpected out_valid", 1, 0);
        end else begin
          exp_item_t e;
          e = sb.pop_front();
          check("R7", "out_buf", out_buf, e.bsel);
          check("R6", "out_addr", out_addr, e.addr);
          check("R6", "out_size", out_size, e.size);
          check("R8", "out_tag", out_tag, e.tag);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("ALL", "watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "out_valid", out_valid, 0);
    check("R11", "block_mask", block_mask, 0);
    check("R1", "cpu_blocked", cpu_blocked, 0);
    check("R11", "events", blk_events, 0);
    check("R11", "cycles", blk_cycles, 0);
    check("R11", "occ", {miss_occ, wbuf_occ}, 0);
    rst_n = 1;
    @(negedge clk);

    // R6 miss, R9 bus cause 0
    step(1, 0, 32'h1234_5678, 4, 1, 0, 0, 0, 0, 0, 0);
    check("R9", "bus_req miss", {bus_req, bus_cause}, {1'b1, 2'd0});
    // R7 write exact, bus cause 1
    step(1, 1, 32'hABCD_0003, 3, 1, 0, 0, 0, 0, 0, 0);
    check("R9", "bus_req write", {bus_req, bus_cause}, {1'b1, 2'd1});
    // R7 uncached read exact, no bus request asked
    step(1, 2, 32'h0000_0101, 2, 0, 0, 0, 0, 0, 0, 0);
    check("R9", "no bus_req", bus_req, 0);
    // R9 retry wait suppresses request
    step(1, 0, 32'h0000_0040, 1, 1, 0, 0, 0, 0, 0, 1);
    check("R9", "retry suppress", bus_req, 0);
    check("R1", "not blocked yet", cpu_blocked, 0);
    // R9 prefetch alone
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R9", "prefetch cause", {bus_req, bus_cause}, {1'b1, 2'd2});

    // R2 write buffer fills, R4 event, R9 allocation wins over prefetch
    blk_seen = 0;
    step(1, 1, 32'h0000_0200, 8, 1, 0, 0, 0, 0, 1, 0);
    check("R9", "alloc beats prefetch", {bus_req, bus_cause}, {1'b1, 2'd1});
    check("R2", "wbuf bit set", block_mask, 3'b010);
    check("R1", "blocked", cpu_blocked, 1);
    check("R4", "events wbuf", ev(1), 1);
    idle(4);
    // R3 alloc + service on full buffer: accepted, stays full
    step(1, 1, 32'h0000_0300, 5, 0, 0, 1, 0, 0, 0, 0);
    check("R3", "full kept", block_mask, 3'b010);
    check("R3", "wbuf occ", wbuf_occ, 2);
    idle(1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    check("R2", "wbuf bit clear", block_mask, 3'b000);
    check("R1", "released", cpu_blocked, 0);
    check("R5", "cycles wbuf", cy(1), blk_seen);
    check("R5", "cycles miss untouched", cy(0), 0);
    // R3 alloc + service below full: no change
    step(1, 1, 32'h0000_0400, 6, 0, 0, 1, 0, 0, 0, 0);
    check("R3", "no set", block_mask, 0);

    // R2 miss pool fills
    blk_seen = 0;
    step(1, 0, 32'h0000_007F, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R2", "miss bit set", block_mask, 3'b001);
    check("R4", "events miss", ev(0), 1);
    // R3 dropped requests
    step(1, 0, 32'h0000_0900, 1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 3, 32'h0000_0A00, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R3", "miss occ held", miss_occ, 4);
    check("R3", "no output on dropped", out_valid, 0);
    // R4 cause set while already blocked
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R2", "tgt bit", block_mask, 3'b101);
    check("R4", "events tgt", ev(2), 0);
    check("R4", "events miss same", ev(0), 1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R2", "miss bit cleared", block_mask, 3'b100);
    check("R1", "still blocked", cpu_blocked, 1);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    check("R5", "mask zero", block_mask, 0);
    check("R5", "cycles tgt", cy(2), blk_seen);
    check("R5", "cycles miss", cy(0), 0);

    // R10 miss limit
    limit_value = 16'd2; limit_load = 1;
    @(negedge clk);
    limit_load = 0;
    step(1, 0, 32'h0000_1000, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R10", "no halt yet", halt_pulse, 0);
    step(1, 0, 32'h0000_2010, 1, 0, 1, 0, 0, 0, 0, 0);
    check("R10", "halt", halt_pulse, 1);
    idle(1);
    check("R10", "halt one cycle", halt_pulse, 0);
    step(1, 0, 32'h0000_3000, 1, 0, 1, 0, 0, 0, 0, 0);
    check("R10", "no halt at zero", halt_pulse, 0);
    idle(2);
    check("R8", "scoreboard drained", sb.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule